// File: doc/BRIEF.md
# Stable Partition Node Encoder

This block performs the work of one internal node in a tree-ordered prefix-code encoder. Every symbol that reaches the node arrives on the symbol input. The block gives it one branch bit: 0 when the symbol belongs to the node's left subtree and 1 when it belongs to the right subtree. It packs these branch bits into bytes. It also forwards the symbol, with the arrival order kept, to the left or the right child stream so that the child nodes can process it in a later pass.

Before a pass, a configuration load installs three things: a membership vector indexed by symbol value, and one flag per child that marks the child as a single leaf. Symbols routed to a leaf child are complete, so that side produces no stream. The pass ends with an end-of-pass strobe. The strobe writes out any partial byte of bits and raises a one-cycle done pulse. The pulse carries the number of symbols that went to each side.

Top module: `part_node_enc`

## Requirements
- R1: An accepted symbol s produces branch bit `cfg_mask_i[s]` as stored at the last configuration load: 0 sends it to the left side and 1 sends it to the right side.
- R2: Each accepted symbol that is not going to a leaf child appears on exactly one of `left_sym_o` or `right_sym_o`, with its valid asserted in the cycle after acceptance. Each output stream keeps the input order.
- R3: Branch bits are packed least significant bit first. The first bit of a pass goes in bit 0. A byte is presented on `bits_o`, with `bits_valid_o` high, in the cycle after its eighth bit is accepted.
- R4: An end-of-pass strobe emits the partial byte with its unused upper bits set to zero, one cycle after the strobe. When no bits are pending, no byte is emitted. A symbol presented in the same cycle as the strobe belongs to the pass.
- R5: When a child is flagged as a leaf, its valid output never rises, although the bits and counts still include the symbols routed to it.
- R6: One cycle after an end-of-pass strobe, `done_o` is high for exactly one cycle. In that cycle `left_cnt_o` and `right_cnt_o` hold the number of 0 bits and the number of 1 bits emitted in the pass.
- R7: A configuration load discards pending bits and counts, replaces the mask and leaf flags, and ignores any symbol or end strobe presented in the same cycle.
- R8: After a done pulse the counts start again from zero, so an end strobe with no symbols reports zero for both sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_ld_i | input | 1 | Load mask and leaf flags, start a new pass |
| cfg_mask_i | input | NSYM | Membership vector, a set bit marks a right-subtree symbol |
| cfg_left_leaf_i | input | 1 | Left child is a single leaf |
| cfg_right_leaf_i | input | 1 | Right child is a single leaf |
| sym_valid_i | input | 1 | Symbol present |
| sym_i | input | SYM_W | Symbol value |
| end_i | input | 1 | End of pass |
| bits_valid_o | output | 1 | Packed bit byte valid |
| bits_o | output | PACK_W | Packed branch bits |
| left_valid_o | output | 1 | Left child symbol valid |
| left_sym_o | output | SYM_W | Left child symbol |
| right_valid_o | output | 1 | Right child symbol valid |
| right_sym_o | output | SYM_W | Right child symbol |
| done_o | output | 1 | End-of-pass pulse |
| left_cnt_o | output | CNT_W | Symbols routed left in the pass |
| right_cnt_o | output | CNT_W | Symbols routed right in the pass |

## Verification
The hardest states to reach are the ones where the end strobe meets the packer at a boundary. In one case the strobe arrives together with the symbol that fills a byte, and no padding byte may follow. In another, a configuration load arrives while a byte is half full, and the stale bits must vanish. The stimulus reaches the first case by sending exactly one byte's worth of symbols with the strobe on the last one. It reaches the second by loading a new configuration after three symbols of a pass and then checking the single padded byte that the next pass produces. A separate case sends a pass that ends with no symbols, which shows that the counts restart after each done pulse.

// File: rtl/part_enc_pkg.sv
package part_enc_pkg;
  localparam int SYM_W_DEF  = 8;
  localparam int CNT_W_DEF  = 16;
  localparam int PACK_W_DEF = 8;

  typedef struct packed {
    logic vld;
    logic right;
  } cls_t;
endpackage

// File: rtl/part_classify.sv
module part_classify
  import part_enc_pkg::*;
#(
  parameter int SYM_W = SYM_W_DEF,
  localparam int NSYM = 1 << SYM_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_ld_i,
  input  logic [NSYM-1:0]  cfg_mask_i,
  input  logic             cfg_lleaf_i,
  input  logic             cfg_rleaf_i,
  input  logic             sym_vld_i,
  input  logic [SYM_W-1:0] sym_i,
  output cls_t             cls_o,
  output logic             lleaf_o,
  output logic             rleaf_o
);
  logic [NSYM-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      lleaf_o <= 1'b0;
      rleaf_o <= 1'b0;
    end else if (cfg_ld_i) begin
      mask_q  <= cfg_mask_i;
      lleaf_o <= cfg_lleaf_i;
      rleaf_o <= cfg_rleaf_i;
    end
  end

  // a load cycle drops the symbol in flight
  always_comb begin
    cls_o.vld   = sym_vld_i && !cfg_ld_i;
    cls_o.right = mask_q[sym_i];
  end
endmodule

// File: rtl/part_bit_pack.sv
module part_bit_pack
  import part_enc_pkg::*;
#(
  parameter int PACK_W = PACK_W_DEF,
  localparam int FILL_W = $clog2(PACK_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              flush_i,
  output logic              byte_vld_o,
  output logic [PACK_W-1:0] byte_o
);
  logic [PACK_W-1:0] acc_q, acc_n;
  logic [FILL_W-1:0] fill_q, fill_n;
  logic              full, emit;

  always_comb begin
    acc_n  = acc_q;
    fill_n = fill_q;
    if (bit_vld_i) begin
      acc_n[fill_q] = bit_i;
      fill_n        = fill_q + FILL_W'(1);
    end
    full = bit_vld_i && (fill_q == FILL_W'(PACK_W - 1));
    emit = full || (flush_i && (bit_vld_i || fill_q != '0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q      <= '0;
      fill_q     <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else if (clr_i) begin
      acc_q      <= '0;
      fill_q     <= '0;
      byte_vld_o <= 1'b0;
    end else begin
      byte_vld_o <= emit;
      if (emit) byte_o <= acc_n;
      acc_q  <= emit ? '0 : acc_n;
      fill_q <= emit ? '0 : fill_n;
    end
  end
endmodule

// File: rtl/part_route.sv
module part_route
  import part_enc_pkg::*;
#(
  parameter int SYM_W = SYM_W_DEF,
  parameter int CNT_W = CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  cls_t             cls_i,
  input  logic [SYM_W-1:0] sym_i,
  input  logic             lleaf_i,
  input  logic             rleaf_i,
  input  logic             end_i,
  output logic             lvld_o,
  output logic [SYM_W-1:0] lsym_o,
  output logic             rvld_o,
  output logic [SYM_W-1:0] rsym_o,
  output logic             done_o,
  output logic [CNT_W-1:0] lcnt_o,
  output logic [CNT_W-1:0] rcnt_o
);
  logic [CNT_W-1:0] lcnt_q, rcnt_q, lcnt_n, rcnt_n;
  logic             go_l, go_r;

  always_comb begin
    go_l   = cls_i.vld && !cls_i.right;
    go_r   = cls_i.vld &&  cls_i.right;
    lcnt_n = lcnt_q + {{(CNT_W-1){1'b0}}, go_l};
    rcnt_n = rcnt_q + {{(CNT_W-1){1'b0}}, go_r};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvld_o <= 1'b0;
      rvld_o <= 1'b0;
      lsym_o <= '0;
      rsym_o <= '0;
      done_o <= 1'b0;
      lcnt_o <= '0;
      rcnt_o <= '0;
      lcnt_q <= '0;
      rcnt_q <= '0;
    end else if (clr_i) begin
      lvld_o <= 1'b0;
      rvld_o <= 1'b0;
      done_o <= 1'b0;
      lcnt_q <= '0;
      rcnt_q <= '0;
    end else begin
      lvld_o <= go_l && !lleaf_i;
      rvld_o <= go_r && !rleaf_i;
      if (go_l) lsym_o <= sym_i;
      if (go_r) rsym_o <= sym_i;
      done_o <= end_i;
      if (end_i) begin
        lcnt_o <= lcnt_n;
        rcnt_o <= rcnt_n;
        lcnt_q <= '0;
        rcnt_q <= '0;
      end else begin
        lcnt_q <= lcnt_n;
        rcnt_q <= rcnt_n;
      end
    end
  end
endmodule

// File: rtl/part_node_enc.sv
module part_node_enc
  import part_enc_pkg::*;
#(
  parameter int SYM_W  = SYM_W_DEF,
  parameter int CNT_W  = CNT_W_DEF,
  parameter int PACK_W = PACK_W_DEF,
  localparam int NSYM  = 1 << SYM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_ld_i,
  input  logic [NSYM-1:0]   cfg_mask_i,
  input  logic              cfg_left_leaf_i,
  input  logic              cfg_right_leaf_i,
  input  logic              sym_valid_i,
  input  logic [SYM_W-1:0]  sym_i,
  input  logic              end_i,
  output logic              bits_valid_o,
  output logic [PACK_W-1:0] bits_o,
  output logic              left_valid_o,
  output logic [SYM_W-1:0]  left_sym_o,
  output logic              right_valid_o,
  output logic [SYM_W-1:0]  right_sym_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  left_cnt_o,
  output logic [CNT_W-1:0]  right_cnt_o
);
  cls_t cls_w;
  logic lleaf_w, rleaf_w, flush_w;

  assign flush_w = end_i && !cfg_ld_i;

  part_classify #(.SYM_W(SYM_W)) u_cls (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_ld_i   (cfg_ld_i),
    .cfg_mask_i (cfg_mask_i),
    .cfg_lleaf_i(cfg_left_leaf_i),
    .cfg_rleaf_i(cfg_right_leaf_i),
    .sym_vld_i  (sym_valid_i),
    .sym_i      (sym_i),
    .cls_o      (cls_w),
    .lleaf_o    (lleaf_w),
    .rleaf_o    (rleaf_w)
  );

  part_bit_pack #(.PACK_W(PACK_W)) u_pack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (cfg_ld_i),
    .bit_vld_i (cls_w.vld),
    .bit_i     (cls_w.right),
    .flush_i   (flush_w),
    .byte_vld_o(bits_valid_o),
    .byte_o    (bits_o)
  );

  part_route #(.SYM_W(SYM_W), .CNT_W(CNT_W)) u_route (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cfg_ld_i),
    .cls_i  (cls_w),
    .sym_i  (sym_i),
    .lleaf_i(lleaf_w),
    .rleaf_i(rleaf_w),
    .end_i  (flush_w),
    .lvld_o (left_valid_o),
    .lsym_o (left_sym_o),
    .rvld_o (right_valid_o),
    .rsym_o (right_sym_o),
    .done_o (done_o),
    .lcnt_o (left_cnt_o),
    .rcnt_o (right_cnt_o)
  );
endmodule

// File: rtl/part_node_enc_chk.sv
module part_node_enc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_ld_i,
  input logic sym_valid_i,
  input logic end_i,
  input logic lleaf_i,
  input logic rleaf_i,
  input logic left_valid_o,
  input logic right_valid_o,
  input logic bits_valid_o,
  input logic done_o
);
  p_one_side_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(left_valid_o && right_valid_o));

  p_route_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_valid_o || right_valid_o) |-> $past(sym_valid_i && !cfg_ld_i));

  p_left_leaf_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lleaf_i |-> !left_valid_o);

  p_right_leaf_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rleaf_i |-> !right_valid_o);

  p_byte_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bits_valid_o |-> $past((sym_valid_i || end_i) && !cfg_ld_i));

  p_done_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(end_i && !cfg_ld_i));

  p_load_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_ld_i |=> !(done_o || bits_valid_o || left_valid_o || right_valid_o));
endmodule

bind part_node_enc part_node_enc_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_ld_i     (cfg_ld_i),
  .sym_valid_i  (sym_valid_i),
  .end_i        (end_i),
  .lleaf_i      (lleaf_w),
  .rleaf_i      (rleaf_w),
  .left_valid_o (left_valid_o),
  .right_valid_o(right_valid_o),
  .bits_valid_o (bits_valid_o),
  .done_o       (done_o)
);

// File: tb/part_node_enc_bench.sv
`timescale 1ns/1ps
module part_node_enc_bench;
  localparam int SYM_W = 8;
  localparam int CNT_W = 16;
  localparam int NSYM  = 256;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_ld = 1'b0;
  logic [NSYM-1:0]  cfg_mask = '0;
  logic             cfg_ll = 1'b0, cfg_rl = 1'b0;
  logic             sym_vld = 1'b0;
  logic [SYM_W-1:0] sym = '0;
  logic             end_s = 1'b0;
  logic             bits_vld, l_vld, r_vld, done;
  logic [7:0]       bits, l_sym, r_sym;
  logic [CNT_W-1:0] l_cnt, r_cnt;

  always #2 clk = ~clk;

  part_node_enc u_part_node_enc (
    .clk_i(clk), .rst_ni(rst_n), .cfg_ld_i(cfg_ld), .cfg_mask_i(cfg_mask),
    .cfg_left_leaf_i(cfg_ll), .cfg_right_leaf_i(cfg_rl),
    .sym_valid_i(sym_vld), .sym_i(sym), .end_i(end_s),
    .bits_valid_o(bits_vld), .bits_o(bits),
    .left_valid_o(l_vld), .left_sym_o(l_sym),
    .right_valid_o(r_vld), .right_sym_o(r_sym),
    .done_o(done), .left_cnt_o(l_cnt), .right_cnt_o(r_cnt)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // observed outputs
  logic [7:0] got_b[$], got_l[$], got_r[$];
  int         got_done = 0;
  logic [CNT_W-1:0] got_lc = '0, got_rc = '0;

  always @(negedge clk) if (rst_n) begin
    if (bits_vld) got_b.push_back(bits);
    if (l_vld) got_l.push_back(l_sym);
    if (r_vld) got_r.push_back(r_sym);
    if (done) begin got_done++; got_lc = l_cnt; got_rc = r_cnt; end
  end

  // reference model
  logic [NSYM-1:0] m_mask = '0;
  bit         m_ll = 0, m_rl = 0;
  logic [7:0] m_acc = '0;
  int         m_n = 0, m_lc = 0, m_rc = 0, m_done = 0;
  logic [7:0] exp_b[$], exp_l[$], exp_r[$];

  task automatic clear_all();
    got_b.delete(); got_l.delete(); got_r.delete(); got_done = 0;
    exp_b.delete(); exp_l.delete(); exp_r.delete();
    m_acc = '0; m_n = 0; m_lc = 0; m_rc = 0; m_done = 0;
  endtask

  task automatic model_flush();
    if (m_n > 0) begin exp_b.push_back(m_acc); m_acc = '0; m_n = 0; end
    m_done++;
  endtask

  task automatic load(input logic [NSYM-1:0] mk, input bit ll, input bit rl,
                      input bit with_sym);
    @(negedge clk);
    cfg_ld = 1'b1; cfg_mask = mk; cfg_ll = ll; cfg_rl = rl;
    sym_vld = with_sym; sym = 8'h41; end_s = with_sym;
    @(negedge clk);
    cfg_ld = 1'b0; sym_vld = 1'b0; end_s = 1'b0;
    m_mask = mk; m_ll = ll; m_rl = rl;
    clear_all();
  endtask

  task automatic send(input logic [7:0] s, input bit last);
    bit b;
    @(negedge clk);
    sym_vld = 1'b1; sym = s; end_s = last;
    b = m_mask[s];
    m_acc[m_n] = b; m_n++;
    if (b) begin m_rc++; if (!m_rl) exp_r.push_back(s); end
    else   begin m_lc++; if (!m_ll) exp_l.push_back(s); end
    if (m_n == 8) begin exp_b.push_back(m_acc); m_acc = '0; m_n = 0; end
    if (last) model_flush();
    @(negedge clk);
    sym_vld = 1'b0; end_s = 1'b0;
  endtask

  task automatic finish_pass();
    @(negedge clk); end_s = 1'b1;
    model_flush();
    @(negedge clk); end_s = 1'b0;
  endtask

  task automatic compare(input string tag);
    repeat (3) @(negedge clk);
    chk(got_b.size() == exp_b.size(), "R3", {tag, " byte count"}, got_b.size(), exp_b.size());
    foreach (exp_b[i]) if (i < got_b.size())
      chk(got_b[i] == exp_b[i], "R1", {tag, " packed bits"}, got_b[i], exp_b[i]);
    chk(got_l.size() == exp_l.size(), "R2", {tag, " left count"}, got_l.size(), exp_l.size());
    foreach (exp_l[i]) if (i < got_l.size())
      chk(got_l[i] == exp_l[i], "R2", {tag, " left order"}, got_l[i], exp_l[i]);
    chk(got_r.size() == exp_r.size(), "R2", {tag, " right count"}, got_r.size(), exp_r.size());
    foreach (exp_r[i]) if (i < got_r.size())
      chk(got_r[i] == exp_r[i], "R2", {tag, " right order"}, got_r[i], exp_r[i]);
    chk(got_done == m_done, "R6", {tag, " done pulses"}, got_done, m_done);
    chk(got_lc == CNT_W'(m_lc), "R6", {tag, " left total"}, got_lc, m_lc);
    chk(got_rc == CNT_W'(m_rc), "R6", {tag, " right total"}, got_rc, m_rc);
  endtask

  // {expected branch bit, symbol}
  localparam logic [8:0] TAB [11] = '{
    {1'b0, 8'h61}, {1'b1, 8'h62}, {1'b1, 8'h72}, {1'b0, 8'h61},
    {1'b1, 8'h63}, {1'b0, 8'h61}, {1'b1, 8'h64}, {1'b0, 8'h61},
    {1'b1, 8'h62}, {1'b1, 8'h72}, {1'b0, 8'h61}};

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [NSYM-1:0] mk;
    int ones;
    repeat (3) @(negedge clk);
    // reset state
    chk(!bits_vld && !l_vld && !r_vld && !done, "R6", "reset valids",
        {bits_vld, l_vld, r_vld, done}, 0);
    chk(l_cnt == 0 && r_cnt == 0, "R6", "reset counts", {l_cnt, r_cnt}, 0);
    rst_n = 1'b1;

    // table pass: only 0x61 goes left, left child is a leaf (R5)
    mk = '1; mk[8'h61] = 1'b0;
    load(mk, 1'b1, 1'b0, 1'b0);
    ones = 0;
    for (int i = 0; i < 11; i++) begin
      send(TAB[i][7:0], 1'b0);
      ones += int'(TAB[i][8]);
    end
    finish_pass();
    compare("table");
    chk(got_b.size() > 0 && got_b[0] == 8'h56, "R3", "first byte lsb first",
        got_b.size() > 0 ? got_b[0] : 8'hxx, 8'h56);
    chk(got_b.size() > 1 && got_b[1] == 8'h03, "R4", "padded tail byte",
        got_b.size() > 1 ? got_b[1] : 8'hxx, 8'h03);
    chk(got_l.size() == 0, "R5", "left leaf silent", got_l.size(), 0);
    chk(got_rc == CNT_W'(ones), "R6", "right total from table", got_rc, ones);

    // full byte with end on the last symbol: no padding byte (R4), counts restart (R8)
    mk = '0;
    for (int v = 128; v < 256; v++) mk[v] = 1'b1;
    load(mk, 1'b0, 1'b0, 1'b0);
    send(8'h10, 0); send(8'h90, 0); send(8'hA0, 0); send(8'h20, 0);
    send(8'hB0, 0); send(8'hC0, 0); send(8'h30, 0); send(8'hF0, 1);
    compare("boundary");
    chk(got_b.size() == 1 && got_b[0] == 8'hB6, "R4", "no pad on full byte",
        got_b.size(), 1);

    // empty pass after a done pulse
    clear_all();
    finish_pass();
    compare("empty");
    chk(got_lc == 0 && got_rc == 0, "R8", "empty pass counts", {got_lc, got_rc}, 0);

    // load mid-pass drops partial state, and the symbol and end in the load cycle (R7)
    send(8'h90, 0); send(8'h91, 0); send(8'h10, 0);
    load('0, 1'b0, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    chk(got_done == 0, "R7", "end ignored during load", got_done, 0);
    send(8'h92, 0);
    finish_pass();
    compare("reload");
    chk(got_b.size() == 1 && got_b[0] == 8'h00, "R7", "stale bits dropped",
        got_b.size() > 0 ? got_b[0] : 8'hxx, 8'h00);

    // right child leaf
    load('1, 1'b0, 1'b1, 1'b0);
    send(8'h05, 0); send(8'h06, 0); send(8'h07, 0);
    finish_pass();
    compare("rleaf");
    chk(got_r.size() == 0, "R5", "right leaf silent", got_r.size(), 0);
    chk(got_b.size() == 1 && got_b[0] == 8'h07, "R1", "all right bits",
        got_b.size() > 0 ? got_b[0] : 8'hxx, 8'h07);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule